// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is the data side of a small 12-bit processor. Every transfer between its registers travels one shared road: a source multiplexer picks one operand, a logic/arithmetic unit either passes it through or combines it with the accumulator, and the result is presented to the data input of every register. A register changes only when its own load strobe is high at a rising clock edge. The control sequencer that drives the selects and strobes sits outside this block, and so does memory.

The multiplexer output feeds the unit's first operand. The accumulator always feeds the second. The unit has a mode input that chooses between bitwise logic functions and arithmetic with a carry input. In arithmetic mode the carry out of the top bit goes into a one-bit link register, but only when the accumulator is loaded. There is no dedicated plus-one function: an increment is the first operand plus a carry-in of one. A switch value enters as an input-only source. The registers, the link and the live bus value are all visible as outputs.

The reset input clears the registers asynchronously. Its release is synchronised, so load strobes take effect from the third rising edge after the reset input goes high.

Top module: `xfer_datapath`

## Requirements
- R1: While reset is asserted and after it is released, the program counter, buffer, address, instruction and accumulator registers and the link all read zero until a load occurs.
- R2: The bus operand source is selected by `src_sel`: code 0 selects the program counter, code 1 selects the buffer register, code 2 selects the address register and code 5 (binary 101) selects `sw_val`.
- R3: With `logic_mode` = 1, the unit ignores `carry_in`. Function 1111 drives the bus with the selected operand, 0000 drives its bitwise inverse and 0011 drives zero.
- R4: With `logic_mode` = 1, function 1110 drives the bus with the operand OR the accumulator, and function 1011 drives it with the operand AND the accumulator.
- R5: With `logic_mode` = 0, function 1001 drives the bus with the low 12 bits of operand + accumulator + `carry_in`, and function 0000 drives operand + `carry_in`. An increment is done this way, and 0xFFF + 1 wraps to 0x000.
- R6: Any function code not named in R3 to R5, in either mode, drives the bus with zero. Source codes 3, 4, 6 and 7 supply zero as the operand.
- R7: A register captures the bus value at a rising edge only when its own load strobe is 1. Otherwise it holds its value.
- R8: When several load strobes are high in the same cycle, every selected register captures the same bus value.
- R9: When `ld_ac` = 1, the link captures the carry out of bit 11. That carry is always 0 in logic mode and for unlisted function codes. When `ld_ac` = 0, the link holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| src_sel | input | 3 | Operand source select |
| fn_sel | input | 4 | Unit function select |
| logic_mode | input | 1 | 1 selects the logic functions, 0 selects the arithmetic functions |
| carry_in | input | 1 | Carry into arithmetic functions |
| sw_val | input | 12 | Switch value, available as source 5 |
| ld_pc | input | 1 | Load strobe for the program counter |
| ld_mb | input | 1 | Load strobe for the buffer register |
| ld_ma | input | 1 | Load strobe for the address register |
| ld_ir | input | 1 | Load strobe for the instruction register |
| ld_ac | input | 1 | Load strobe for the accumulator and the link |
| bus_q | output | 12 | Live result bus |
| pc_q | output | 12 | Program counter contents |
| mb_q | output | 12 | Buffer register contents |
| ma_q | output | 12 | Address register contents |
| ir_q | output | 12 | Instruction register contents |
| ac_q | output | 12 | Accumulator contents |
| link_q | output | 1 | Link bit |

## Verification
The bus is combinational, so it reflects a new select, function, carry or switch value within the same cycle. The bench therefore checks it a short settle time after driving those inputs at the falling edge, before the next rising edge. Register and link results appear one rising edge after the strobe, so they are compared at the following falling edge against a bench-side model that updates only for the strobes that were driven. Because the reset release takes two flops to pass through, stimulus begins several edges after reset is released, which keeps every expected value in step with the design.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  parameter int unsigned DW   = 12;
  parameter int unsigned SELW = 3;
  parameter int unsigned FNW  = 4;

  // register slots in the load-strobe vector
  localparam int unsigned SLOT_PC = 0;
  localparam int unsigned SLOT_MB = 1;
  localparam int unsigned SLOT_MA = 2;
  localparam int unsigned SLOT_IR = 3;
  localparam int unsigned SLOT_AC = 4;
  localparam int unsigned NREG    = 5;

  // operand source codes
  localparam logic [SELW-1:0] SRC_PC = 3'd0;
  localparam logic [SELW-1:0] SRC_MB = 3'd1;
  localparam logic [SELW-1:0] SRC_MA = 3'd2;
  localparam logic [SELW-1:0] SRC_SW = 3'd5;

  // logic-mode functions
  localparam logic [FNW-1:0] FN_PASS = 4'b1111;
  localparam logic [FNW-1:0] FN_NOT  = 4'b0000;
  localparam logic [FNW-1:0] FN_ZERO = 4'b0011;
  localparam logic [FNW-1:0] FN_OR   = 4'b1110;
  localparam logic [FNW-1:0] FN_AND  = 4'b1011;
  // arithmetic-mode functions
  localparam logic [FNW-1:0] FN_ADD  = 4'b1001;
  localparam logic [FNW-1:0] FN_INC  = 4'b0000;
endpackage

// File: rtl/xfer_reg.sv
module xfer_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/xfer_src_mux.sv
module xfer_src_mux #(
  parameter int unsigned W    = 12,
  parameter int unsigned SELW = 3,
  localparam int unsigned NSRC = 1 << SELW
) (
  input  logic [NSRC-1:0][W-1:0] src,
  input  logic [SELW-1:0]        sel,
  output logic [W-1:0]           opnd
);
  always_comb begin
    opnd = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SELW'(i)) opnd = src[i];
    end
  end
endmodule

// File: rtl/xfer_alu.sv
module xfer_alu
  import xfer_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [FNW-1:0] fn,
  input  logic           lmode,
  input  logic           cin,
  output logic [W-1:0]   f,
  output logic           cout
);
  logic [W:0] sum_ab;
  logic [W:0] sum_a;

  always_comb begin
    sum_ab = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum_a  = {1'b0, a} + {{W{1'b0}}, cin};
  end

  always_comb begin
    f    = '0;
    cout = 1'b0;
    if (lmode) begin
      unique case (fn)
        FN_PASS: f = a;
        FN_NOT:  f = ~a;
        FN_ZERO: f = '0;
        FN_OR:   f = a | b;
        FN_AND:  f = a & b;
        default: f = '0;
      endcase
    end else begin
      unique case (fn)
        FN_ADD:  {cout, f} = sum_ab;
        FN_INC:  {cout, f} = sum_a;
        default: begin
          f    = '0;
          cout = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int unsigned DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SELW-1:0]   src_sel,
  input  logic [FNW-1:0]    fn_sel,
  input  logic              logic_mode,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] sw_val,
  input  logic              ld_pc,
  input  logic              ld_mb,
  input  logic              ld_ma,
  input  logic              ld_ir,
  input  logic              ld_ac,
  output logic [DATA_W-1:0] bus_q,
  output logic [DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0] mb_q,
  output logic [DATA_W-1:0] ma_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] ac_q,
  output logic              link_q
);
  localparam int unsigned NSRC = 1 << SELW;

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [NREG-1:0]             ld_vec;
  logic [NREG-1:0][DATA_W-1:0] q_vec;
  logic [NSRC-1:0][DATA_W-1:0] src_vec;
  logic [DATA_W-1:0]           opnd;
  logic [DATA_W-1:0]           bus;
  logic                        cout;

  always_comb begin
    ld_vec          = '0;
    ld_vec[SLOT_PC] = ld_pc;
    ld_vec[SLOT_MB] = ld_mb;
    ld_vec[SLOT_MA] = ld_ma;
    ld_vec[SLOT_IR] = ld_ir;
    ld_vec[SLOT_AC] = ld_ac;
  end

  always_comb begin
    src_vec         = '0;
    src_vec[SRC_PC] = q_vec[SLOT_PC];
    src_vec[SRC_MB] = q_vec[SLOT_MB];
    src_vec[SRC_MA] = q_vec[SLOT_MA];
    src_vec[SRC_SW] = sw_val;
  end

  xfer_src_mux #(.W(DATA_W), .SELW(SELW)) u_mux (
    .src  (src_vec),
    .sel  (src_sel),
    .opnd (opnd)
  );

  xfer_alu #(.W(DATA_W)) u_alu (
    .a     (opnd),
    .b     (q_vec[SLOT_AC]),
    .fn    (fn_sel),
    .lmode (logic_mode),
    .cin   (carry_in),
    .f     (bus),
    .cout  (cout)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    xfer_reg #(.W(DATA_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_q_n),
      .ld    (ld_vec[g]),
      .d     (bus),
      .q     (q_vec[g])
    );
  end

  xfer_reg #(.W(1)) u_link (
    .clk   (clk),
    .rst_n (rst_q_n),
    .ld    (ld_ac),
    .d     (cout),
    .q     (link_q)
  );

  assign bus_q = bus;
  assign pc_q  = q_vec[SLOT_PC];
  assign mb_q  = q_vec[SLOT_MB];
  assign ma_q  = q_vec[SLOT_MA];
  assign ir_q  = q_vec[SLOT_IR];
  assign ac_q  = q_vec[SLOT_AC];
endmodule

// File: rtl/xfer_datapath_chk.sv
module xfer_datapath_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic [2:0]    src_sel,
  input logic [3:0]    fn_sel,
  input logic          logic_mode,
  input logic          carry_in,
  input logic          ld_pc,
  input logic          ld_mb,
  input logic          ld_ma,
  input logic          ld_ir,
  input logic          ld_ac,
  input logic [DW-1:0] bus_q,
  input logic [DW-1:0] pc_q,
  input logic [DW-1:0] mb_q,
  input logic [DW-1:0] ma_q,
  input logic [DW-1:0] ir_q,
  input logic [DW-1:0] ac_q,
  input logic          link_q
);
  logic [DW-1:0] ma_plus_cin;
  assign ma_plus_cin = ma_q + {{(DW-1){1'b0}}, carry_in};

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld_pc |=> $stable(pc_q));
  // R7
  ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld_ac |=> $stable(ac_q));
  // R8
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_pc |=> pc_q == $past(bus_q));
  // R8
  mb_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_mb |=> mb_q == $past(bus_q));
  // R8
  ma_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_ma |=> ma_q == $past(bus_q));
  // R8
  ir_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_ir |=> ir_q == $past(bus_q));
  // R8
  ac_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_ac |=> ac_q == $past(bus_q));
  // R9
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld_ac |=> $stable(link_q));
  // R9
  link_logic_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_ac && logic_mode) |=> !link_q);
  // R3
  zero_fn_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (logic_mode && fn_sel == 4'b0011) |-> bus_q == '0);
  // R4
  and_fn_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (logic_mode && fn_sel == 4'b1011) |-> (bus_q & ~ac_q) == '0);
  // R5
  inc_ma_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!logic_mode && fn_sel == 4'b0000 && src_sel == 3'd2) |-> bus_q == ma_plus_cin);
  // R6
  dead_src_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (logic_mode && fn_sel == 4'b1111 &&
     (src_sel == 3'd3 || src_sel == 3'd4 || src_sel == 3'd6 || src_sel == 3'd7))
    |-> bus_q == '0);
endmodule

bind xfer_datapath xfer_datapath_chk #(.DW(DATA_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .src_sel    (src_sel),
  .fn_sel     (fn_sel),
  .logic_mode (logic_mode),
  .carry_in   (carry_in),
  .ld_pc      (ld_pc),
  .ld_mb      (ld_mb),
  .ld_ma      (ld_ma),
  .ld_ir      (ld_ir),
  .ld_ac      (ld_ac),
  .bus_q      (bus_q),
  .pc_q       (pc_q),
  .mb_q       (mb_q),
  .ma_q       (ma_q),
  .ir_q       (ir_q),
  .ac_q       (ac_q),
  .link_q     (link_q)
);

// File: tb/xfer_datapath_bench.sv
`timescale 1ns/100ps
module xfer_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [2:0]  src_sel = '0;
  logic [3:0]  fn_sel = '0;
  logic        logic_mode = 1'b1;
  logic        carry_in = 1'b0;
  logic [11:0] sw_val = '0;
  logic        ld_pc = 0, ld_mb = 0, ld_ma = 0, ld_ir = 0, ld_ac = 0;
  logic [11:0] bus_q, pc_q, mb_q, ma_q, ir_q, ac_q;
  logic        link_q;

  int checks = 0;
  int errors = 0;
  logic [11:0] e_pc = 0, e_mb = 0, e_ma = 0, e_ir = 0, e_ac = 0;
  logic        e_link = 0;

  always #2.5 clk = ~clk;

  xfer_datapath u_xfer_datapath (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .fn_sel(fn_sel),
    .logic_mode(logic_mode), .carry_in(carry_in), .sw_val(sw_val),
    .ld_pc(ld_pc), .ld_mb(ld_mb), .ld_ma(ld_ma), .ld_ir(ld_ir), .ld_ac(ld_ac),
    .bus_q(bus_q), .pc_q(pc_q), .mb_q(mb_q), .ma_q(ma_q), .ir_q(ir_q),
    .ac_q(ac_q), .link_q(link_q)
  );

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference result from the requirement text: {carry, value}
  function automatic logic [12:0] model(input logic [2:0] s, input logic [3:0] fn,
                                        input logic lm, input logic ci, input logic [11:0] sw);
    logic [11:0] a;
    case (s)
      3'd0: a = e_pc;
      3'd1: a = e_mb;
      3'd2: a = e_ma;
      3'd5: a = sw;
      default: a = 12'h000;
    endcase
    if (lm) begin
      if (fn == 4'b1111)      return {1'b0, a};
      else if (fn == 4'b0000) return {1'b0, ~a};
      else if (fn == 4'b1110) return {1'b0, a | e_ac};
      else if (fn == 4'b1011) return {1'b0, a & e_ac};
      else                    return 13'h0;
    end else begin
      if (fn == 4'b1001)      return {1'b0, a} + {1'b0, e_ac} + 13'(ci);
      else if (fn == 4'b0000) return {1'b0, a} + 13'(ci);
      else                    return 13'h0;
    end
  endfunction

  task automatic check_regs(input string tag);
    check({tag, " pc"}, {1'b0, pc_q}, {1'b0, e_pc});
    check({tag, " mb"}, {1'b0, mb_q}, {1'b0, e_mb});
    check({tag, " ma"}, {1'b0, ma_q}, {1'b0, e_ma});
    check({tag, " ir"}, {1'b0, ir_q}, {1'b0, e_ir});
    check({tag, " ac"}, {1'b0, ac_q}, {1'b0, e_ac});
    check({tag, " link"}, {12'h0, link_q}, {12'h0, e_link});
  endtask

  // one transfer: ld = {ac, ir, ma, mb, pc}
  task automatic step(input string tag, input logic [2:0] s, input logic [3:0] fn,
                      input logic lm, input logic ci, input logic [11:0] sw,
                      input logic [4:0] ld);
    logic [12:0] r;
    @(negedge clk);
    src_sel = s; fn_sel = fn; logic_mode = lm; carry_in = ci; sw_val = sw;
    {ld_ac, ld_ir, ld_ma, ld_mb, ld_pc} = ld;
    #1;
    r = model(s, fn, lm, ci, sw);
    check({tag, " bus"}, {1'b0, bus_q}, {1'b0, r[11:0]});
    @(posedge clk);
    @(negedge clk);
    {ld_ac, ld_ir, ld_ma, ld_mb, ld_pc} = 5'b0;
    if (ld[0]) e_pc = r[11:0];
    if (ld[1]) e_mb = r[11:0];
    if (ld[2]) e_ma = r[11:0];
    if (ld[3]) e_ir = r[11:0];
    if (ld[4]) begin e_ac = r[11:0]; e_link = r[12]; end
    check_regs(tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #1;
    check_regs("R1 in reset");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_regs("R1 after release");
  endtask

  task automatic t_mux;
    step("R2 sw->pc", 3'd5, 4'b1111, 1, 0, 12'hA5C, 5'b00001);
    step("R2 sw->mb", 3'd5, 4'b1111, 1, 0, 12'h3F0, 5'b00010);
    step("R2 sw->ma", 3'd5, 4'b1111, 1, 0, 12'h7E1, 5'b00100);
    step("R2 pc->ir", 3'd0, 4'b1111, 1, 0, 12'h000, 5'b01000);
    step("R2 mb->ir", 3'd1, 4'b1111, 1, 0, 12'h000, 5'b01000);
    step("R2 ma->ir", 3'd2, 4'b1111, 1, 0, 12'h000, 5'b01000);
  endtask

  task automatic t_dead_src;
    step("R6 src3", 3'd3, 4'b1111, 1, 0, 12'hFFF, 5'b01000);
    step("R6 src4", 3'd4, 4'b1111, 1, 0, 12'hFFF, 5'b00000);
    step("R6 src6", 3'd6, 4'b1111, 1, 0, 12'hFFF, 5'b00000);
    step("R6 src7", 3'd7, 4'b1111, 1, 0, 12'hFFF, 5'b00000);
  endtask

  task automatic t_logic;
    step("R3 sw->ac", 3'd5, 4'b1111, 1, 0, 12'h0F3, 5'b10000);
    step("R3 pass ignores carry", 3'd5, 4'b1111, 1, 1, 12'h5A5, 5'b00000);
    step("R3 not", 3'd5, 4'b0000, 1, 1, 12'h5A5, 5'b01000);
    step("R3 zero", 3'd5, 4'b0011, 1, 0, 12'h5A5, 5'b01000);
    step("R4 or", 3'd5, 4'b1110, 1, 0, 12'h5A5, 5'b01000);
    step("R4 and", 3'd5, 4'b1011, 1, 0, 12'h5A5, 5'b00001);
  endtask

  task automatic t_arith;
    step("R5 add carry", 3'd5, 4'b1001, 0, 1, 12'hF20, 5'b10000);
    check("R9 link set by add", {12'h0, link_q}, 13'h1);
    step("R9 link hold", 3'd5, 4'b1001, 0, 1, 12'hFFF, 5'b00001);
    step("R5 inc ma", 3'd2, 4'b0000, 0, 1, 12'h000, 5'b00100);
    step("R5 ma no carry", 3'd2, 4'b0000, 0, 0, 12'h000, 5'b00100);
    step("R5 load fff", 3'd5, 4'b1111, 1, 0, 12'hFFF, 5'b00100);
    step("R5 wrap", 3'd2, 4'b0000, 0, 1, 12'h000, 5'b10100);
    check("R5 wrap ma", {1'b0, ma_q}, 13'h000);
    check("R9 wrap link", {12'h0, link_q}, 13'h1);
    step("R9 logic clears link", 3'd5, 4'b1111, 1, 1, 12'h123, 5'b10000);
  endtask

  task automatic t_unlisted;
    step("R6 logic 0101", 3'd5, 4'b0101, 1, 1, 12'hABC, 5'b01000);
    step("R6 arith 0110", 3'd5, 4'b0110, 0, 1, 12'hFFF, 5'b10000);
    check("R6 arith no carry", {12'h0, link_q}, 13'h0);
    step("R6 arith 1111", 3'd5, 4'b1111, 0, 1, 12'hABC, 5'b00001);
  endtask

  task automatic t_strobes;
    step("R7 ir only", 3'd5, 4'b1111, 1, 0, 12'h9C3, 5'b01000);
    step("R7 none", 3'd5, 4'b1111, 1, 0, 12'h111, 5'b00000);
    step("R8 all", 3'd5, 4'b1111, 1, 0, 12'h6B2, 5'b11111);
    step("R8 pair", 3'd0, 4'b0000, 0, 1, 12'h000, 5'b00110);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mux();
    t_dead_src();
    t_logic();
    t_arith();
    t_unlisted();
    t_strobes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule